// File: doc/BRIEF.md
# Privilege-Aware Memory Permission Checker

This block decides, in the same cycle, whether one memory access may proceed. It receives the privilege of the access (machine, or supervisor/user), the kind of access (read, write or instruction fetch), and a vector showing which protection entries cover the address. Address comparison happens upstream and produces that vector. It also receives each entry's owner/lock bit and its read, write and execute bits, plus two global flags. The first flag, `mml`, selects a second permission decode. The second flag, `mmwp`, makes the machine-mode default deny-by-default.

The checker returns a single allow/deny answer. It also reports whether any entry matched and the index of the entry that decided the result. Exception reporting stays with the caller. When `mml` is set, the lock bit stops meaning "locked". It then says which privilege owns the rule, and some encodings describe shared code or shared data regions. Under `mml`, a machine-mode fetch can only succeed from a rule that machine mode owns or from a locked shared-code rule.

The block is purely combinational. It has no clock, no state and no handshake: each answer depends only on the present inputs.

Top module: `pmpchk_top`

## Requirements
- R1: `acc_type` codes are 2'b00 read, 2'b01 write and 2'b10 fetch. The reserved code 2'b11 is always denied.
- R2: When several entries match, only the lowest-index one decides. `hit` is 1 if any bit of `match_vec` is set, and `idx` then holds the lowest set bit position. With no match, `hit` and `idx` are both 0.
- R3: With `mml`=0, a supervisor/user access to a matching entry is allowed exactly when that entry's bit for the access type is set: `cfg_r` for read, `cfg_w` for write, `cfg_x` for fetch.
- R4: With `mml`=0, a machine-mode access whose deciding entry has `cfg_l`=0 is allowed for every access type. If the deciding entry has `cfg_l`=1, the R3 bit rule applies.
- R5: With `mml`=1 and `cfg_l`=0, the grants by rwx are as follows. Machine mode gets 010 and 011 as read/write and everything else denied. Supervisor/user gets 000 none, 001 fetch only, 010 read only, 011 read/write, 100 read, 101 read/fetch, 110 read/write and 111 all.
- R6: With `mml`=1 and `cfg_l`=1, the grants by rwx are as follows. Machine mode gets 000 none, 001 fetch, 010 fetch, 011 read/fetch, 100 read, 101 read/fetch, 110 read/write and 111 read. Supervisor/user gets 010 and 011 as fetch only, 111 as read only, and everything else denied.
- R7: A supervisor/user access that matches no entry is denied.
- R8: A machine-mode access that matches no entry is allowed when `mmwp`=0 and denied when `mmwp`=1. With `mml`=1, a no-match machine-mode fetch is always denied.
- R9: With `mml`=1, an allowed machine-mode fetch always has a matching deciding entry with `cfg_l`=1.
- R10: The entry count `N_ENTRIES` is a parameter from 1 to 64. `idx` is max(1, clog2(N_ENTRIES)) bits wide, and a one-entry build behaves by the same rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| priv_m | input | 1 | 1 = machine-mode access, 0 = supervisor/user |
| acc_type | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| match_vec | input | N_ENTRIES | Bit i set when entry i covers the address |
| cfg_l | input | N_ENTRIES | Per-entry lock/owner bit |
| cfg_r | input | N_ENTRIES | Per-entry read bit |
| cfg_w | input | N_ENTRIES | Per-entry write bit |
| cfg_x | input | N_ENTRIES | Per-entry execute bit |
| mml | input | 1 | Selects the owner-based permission decode |
| mmwp | input | 1 | Deny machine-mode accesses that match nothing |
| allow | output | 1 | 1 = access permitted |
| hit | output | 1 | 1 = at least one entry matched |
| idx | output | IDX_W | Index of the deciding entry (0 when no hit) |

## Verification
The embedded assertions check the structural invariants on every evaluation. These are: the winning entry really matches and no lower one does, the reserved access code is refused, no-match supervisor/user and `mmwp` denials hold, and every machine-mode fetch allowed under `mml` traces back to a locked entry. Only the bench's sweeps can show the exact contents of the two 8-row decode tables for each privilege, and that the baseline decode lets machine mode through unlocked entries. They also show that a higher-index entry with different bits is truly shadowed and that a one-entry build obeys the same rules.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_X    = 3'b001;
  localparam perm_t P_R    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RW   = 3'b110;
  localparam perm_t P_RWX  = 3'b111;

endpackage

// File: rtl/pmpchk_entry_decode.sv
module pmpchk_entry_decode
  import pmpchk_pkg::*;
(
  input  logic       priv_m,
  input  logic       mml,
  input  logic       lk,
  input  logic [2:0] rwx,
  output perm_t      grant
);

  perm_t m_perm;
  perm_t su_perm;

  // Owner-based decode, both privileges at once (R5, R6)
  always_comb begin
    m_perm  = P_NONE;
    su_perm = P_NONE;
    unique case ({lk, rwx})
      4'b0_000: begin m_perm = P_NONE; su_perm = P_NONE; end
      4'b0_001: begin m_perm = P_NONE; su_perm = P_X;    end
      4'b0_010: begin m_perm = P_RW;   su_perm = P_R;    end
      4'b0_011: begin m_perm = P_RW;   su_perm = P_RW;   end
      4'b0_100: begin m_perm = P_NONE; su_perm = P_R;    end
      4'b0_101: begin m_perm = P_NONE; su_perm = P_RX;   end
      4'b0_110: begin m_perm = P_NONE; su_perm = P_RW;   end
      4'b0_111: begin m_perm = P_NONE; su_perm = P_RWX;  end
      4'b1_000: begin m_perm = P_NONE; su_perm = P_NONE; end
      4'b1_001: begin m_perm = P_X;    su_perm = P_NONE; end
      4'b1_010: begin m_perm = P_X;    su_perm = P_X;    end
      4'b1_011: begin m_perm = P_RX;   su_perm = P_X;    end
      4'b1_100: begin m_perm = P_R;    su_perm = P_NONE; end
      4'b1_101: begin m_perm = P_RX;   su_perm = P_NONE; end
      4'b1_110: begin m_perm = P_RW;   su_perm = P_NONE; end
      4'b1_111: begin m_perm = P_R;    su_perm = P_R;    end
      default:  begin m_perm = P_NONE; su_perm = P_NONE; end
    endcase
  end

  // Baseline vs owner-based selection (R3, R4)
  always_comb begin
    if (!mml) begin
      if (priv_m && !lk) grant = P_RWX;
      else               grant = perm_t'(rwx);
    end else begin
      grant = priv_m ? m_perm : su_perm;
    end
  end

  // Machine mode never executes from an unlocked rule under owner decode
  always_comb begin
    if (mml && priv_m && !lk)
      assert_unlocked_no_mexec_R9: assert (!grant.ex)
        else $error("R9: unlocked entry grants machine execute");
  end

endmodule

// File: rtl/pmpchk_prio.sv
module pmpchk_prio #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] match,
  output logic [N_ENTRIES-1:0] first,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  logic [N_ENTRIES:0] below;

  assign below[0] = 1'b0;

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chain
      assign first[g]   = match[g] & ~below[g];
      assign below[g+1] = below[g] | match[g];
    end
  endgenerate

  assign hit = below[N_ENTRIES];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

  always_comb begin
    assert_single_winner_R2: assert ($onehot0(first))
      else $error("R2: more than one winning entry");
    assert_hit_consistent_R2: assert (hit == (match != '0))
      else $error("R2: hit disagrees with match vector");
  end

endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
  import pmpchk_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 priv_m,
  input  logic [1:0]           acc_type,
  input  logic [N_ENTRIES-1:0] match_vec,
  input  logic [N_ENTRIES-1:0] cfg_l,
  input  logic [N_ENTRIES-1:0] cfg_r,
  input  logic [N_ENTRIES-1:0] cfg_w,
  input  logic [N_ENTRIES-1:0] cfg_x,
  input  logic                 mml,
  input  logic                 mmwp,
  output logic                 allow,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  perm_t                ent_perm [N_ENTRIES];
  logic [N_ENTRIES-1:0] first;
  perm_t                sel_perm;
  acc_e                 acc;
  logic                 hit_ok;
  logic                 miss_ok;

  assign acc = acc_e'(acc_type);

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      pmpchk_entry_decode u_dec (
        .priv_m (priv_m),
        .mml    (mml),
        .lk     (cfg_l[g]),
        .rwx    ({cfg_r[g], cfg_w[g], cfg_x[g]}),
        .grant  (ent_perm[g])
      );
    end
  endgenerate

  pmpchk_prio #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
  ) u_prio (
    .match (match_vec),
    .first (first),
    .hit   (hit),
    .idx   (idx)
  );

  // One-hot select of the deciding entry's permissions (R2)
  always_comb begin
    sel_perm = P_NONE;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (first[i]) sel_perm = sel_perm | ent_perm[i];
    end
  end

  always_comb begin
    unique case (acc)
      ACC_READ:  hit_ok = sel_perm.rd;
      ACC_WRITE: hit_ok = sel_perm.wr;
      ACC_FETCH: hit_ok = sel_perm.ex;
      default:   hit_ok = 1'b0;
    endcase
  end

  // No-match defaults (R7, R8)
  always_comb begin
    if (!priv_m)                  miss_ok = 1'b0;
    else if (acc == ACC_RSVD)     miss_ok = 1'b0;
    else if (mml && acc == ACC_FETCH) miss_ok = 1'b0;
    else                          miss_ok = !mmwp;
  end

  assign allow = hit ? hit_ok : miss_ok;

  logic [N_ENTRIES-1:0] lower_mask;
  assign lower_mask = (N_ENTRIES'(1) << idx) - N_ENTRIES'(1);

  always_comb begin
    assert_reserved_denied_R1: assert (!(acc_type == 2'b11 && allow))
      else $error("R1: reserved access code allowed");
    if (hit) begin
      assert_winner_matches_R2: assert (match_vec[idx])
        else $error("R2: deciding entry does not match");
      assert_no_lower_match_R2: assert ((match_vec & lower_mask) == '0)
        else $error("R2: a lower entry also matched");
    end else begin
      assert_idle_index_R2: assert (idx == '0)
        else $error("R2: index nonzero without a hit");
    end
    if (!mml && priv_m && hit && !cfg_l[idx] && acc_type != 2'b11)
      assert_m_unlocked_pass_R4: assert (allow)
        else $error("R4: machine access through unlocked entry refused");
    if (!priv_m && !hit)
      assert_su_miss_denied_R7: assert (!allow)
        else $error("R7: supervisor/user no-match allowed");
    if (priv_m && !hit && mmwp)
      assert_m_miss_whitelist_R8: assert (!allow)
        else $error("R8: machine no-match allowed under mmwp");
    if (mml && priv_m && acc_type == 2'b10 && allow)
      assert_m_fetch_locked_R9: assert (hit && cfg_l[idx])
        else $error("R9: machine fetch allowed from non-locked source");
  end

endmodule

// File: tb/pmpchk_top_tb_top.sv
module pmpchk_top_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic         priv_m;
  logic [1:0]   acc_type;
  logic [N-1:0] match_vec, cfg_l, cfg_r, cfg_w, cfg_x;
  logic         mml, mmwp;
  logic         allow, hit;
  logic [1:0]   idx;

  pmpchk_top #(.N_ENTRIES(N)) dut_i (
    .priv_m(priv_m), .acc_type(acc_type), .match_vec(match_vec),
    .cfg_l(cfg_l), .cfg_r(cfg_r), .cfg_w(cfg_w), .cfg_x(cfg_x),
    .mml(mml), .mmwp(mmwp), .allow(allow), .hit(hit), .idx(idx)
  );

  logic       s_m, s_match, s_l, s_r, s_w, s_x, s_mml, s_mmwp;
  logic [1:0] s_acc;
  logic       s_allow, s_hit, s_idx;

  pmpchk_top #(.N_ENTRIES(1)) dut_one_i (
    .priv_m(s_m), .acc_type(s_acc), .match_vec(s_match),
    .cfg_l(s_l), .cfg_r(s_r), .cfg_w(s_w), .cfg_x(s_x),
    .mml(s_mml), .mmwp(s_mmwp), .allow(s_allow), .hit(s_hit), .idx(s_idx)
  );

  // Reference grant for a matched entry, as {rd,wr,ex}
  function automatic logic [2:0] ref_perm(logic m, logic ml, logic l, logic [2:0] rwx);
    logic [2:0] mp, sp;
    if (!ml) return (m && !l) ? 3'b111 : rwx;
    if (!l) begin
      mp = (rwx == 3'b010 || rwx == 3'b011) ? 3'b110 : 3'b000;
      case (rwx)
        3'b001: sp = 3'b001; 3'b010: sp = 3'b100; 3'b011: sp = 3'b110;
        3'b000: sp = 3'b000; default: sp = rwx;
      endcase
    end else begin
      case (rwx)
        3'b000: mp = 3'b000; 3'b001: mp = 3'b001; 3'b010: mp = 3'b001;
        3'b011: mp = 3'b101; 3'b111: mp = 3'b100; default: mp = rwx;
      endcase
      sp = (rwx == 3'b010 || rwx == 3'b011) ? 3'b001 :
           (rwx == 3'b111) ? 3'b100 : 3'b000;
    end
    return m ? mp : sp;
  endfunction

  function automatic logic ref_allow(logic m, logic [1:0] a, logic ml, logic wp,
                                     logic h, logic l, logic [2:0] rwx);
    logic [2:0] p;
    if (a == 2'b11) return 1'b0;
    if (!h) begin
      if (!m) return 1'b0;
      if (ml && a == 2'b10) return 1'b0;
      return !wp;
    end
    p = ref_perm(m, ml, l, rwx);
    return (a == 2'b00) ? p[2] : (a == 2'b01) ? p[1] : p[0];
  endfunction

  function automatic string req_of(logic m, logic [1:0] a, logic ml, logic h);
    if (a == 2'b11) return "R1";
    if (!h) return m ? "R8" : "R7";
    if (ml && m && a == 2'b10) return "R9";
    if (!ml) return m ? "R4" : "R3";
    return "R5/R6";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    priv_m = 0; acc_type = 0; match_vec = 0; cfg_l = 0; cfg_r = 0;
    cfg_w = 0; cfg_x = 0; mml = 0; mmwp = 0;
    s_m = 0; s_acc = 0; s_match = 0; s_l = 0; s_r = 0; s_w = 0; s_x = 0;
    s_mml = 0; s_mmwp = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: nothing matches, supervisor/user read (R7, R2)
    @(negedge clk); #1;
    check("R7", "idle allow", allow, 0);
    check("R2", "idle hit", hit, 0);
    check("R2", "idle idx", idx, 0);

    // Single-entry sweep over every config, mode and access (R1, R3-R6, R9)
    for (int e = 0; e < N; e++)
      for (int cfg = 0; cfg < 16; cfg++)
        for (int ml = 0; ml < 2; ml++)
          for (int wp = 0; wp < 2; wp++)
            for (int m = 0; m < 2; m++)
              for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                cfg_l = 4'b1010; cfg_r = 4'b0101; cfg_w = 4'b1111; cfg_x = 4'b0000;
                cfg_l[e] = cfg[3]; cfg_r[e] = cfg[2]; cfg_w[e] = cfg[1]; cfg_x[e] = cfg[0];
                match_vec = 4'(1 << e);
                priv_m = m[0]; acc_type = a[1:0]; mml = ml[0]; mmwp = wp[0];
                #1;
                check(req_of(m[0], a[1:0], ml[0], 1'b1), "single allow", allow,
                      ref_allow(m[0], a[1:0], ml[0], wp[0], 1'b1, cfg[3], cfg[2:0]));
                check("R2", "single idx", idx, e);
              end

    // No-match sweep (R7, R8)
    for (int ml = 0; ml < 2; ml++)
      for (int wp = 0; wp < 2; wp++)
        for (int m = 0; m < 2; m++)
          for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            match_vec = '0; cfg_l = 4'b1111; cfg_r = 4'b1111; cfg_w = 4'b1111; cfg_x = 4'b1111;
            priv_m = m[0]; acc_type = a[1:0]; mml = ml[0]; mmwp = wp[0];
            #1;
            check(req_of(m[0], a[1:0], ml[0], 1'b0), "miss allow", allow,
                  ref_allow(m[0], a[1:0], ml[0], wp[0], 1'b0, 1'b0, 3'b000));
            check("R2", "miss hit", hit, 0);
          end

    // Priority among overlapping entries with distinct configs (R2)
    for (int mv = 1; mv < 16; mv++)
      for (int ml = 0; ml < 2; ml++)
        for (int m = 0; m < 2; m++)
          for (int a = 0; a < 3; a++) begin
            int lo;
            lo = 0;
            for (int b = N - 1; b >= 0; b--) if (mv[b]) lo = b;
            @(negedge clk);
            cfg_l = 4'b0110; cfg_r = 4'b1001; cfg_w = 4'b0011; cfg_x = 4'b0101;
            match_vec = mv[3:0]; priv_m = m[0]; acc_type = a[1:0]; mml = ml[0]; mmwp = 1'b0;
            #1;
            check("R2", "prio idx", idx, lo);
            check("R2", "prio hit", hit, 1);
            check("R2", "prio allow", allow,
                  ref_allow(m[0], a[1:0], ml[0], 1'b0, 1'b1, cfg_l[lo],
                            {cfg_r[lo], cfg_w[lo], cfg_x[lo]}));
          end

    // One-entry build (R10)
    for (int cfg = 0; cfg < 16; cfg++)
      for (int mt = 0; mt < 2; mt++)
        for (int ml = 0; ml < 2; ml++)
          for (int m = 0; m < 2; m++)
            for (int a = 0; a < 4; a++) begin
              @(negedge clk);
              s_l = cfg[3]; s_r = cfg[2]; s_w = cfg[1]; s_x = cfg[0];
              s_match = mt[0]; s_mml = ml[0]; s_mmwp = cfg[0]; s_m = m[0]; s_acc = a[1:0];
              #1;
              check("R10", "one-entry allow", s_allow,
                    ref_allow(m[0], a[1:0], ml[0], cfg[0], mt[0], cfg[3], cfg[2:0]));
              check("R10", "one-entry hit", s_hit, mt);
              check("R10", "one-entry idx", s_idx, 0);
            end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule